// File: doc/BRIEF.md
# Walking-Ones Data Line Self-Test Engine

This block is a built-in self-test engine that exercises the data wires between a controller and a synchronous single-port memory. A start pulse launches a run. During the run the engine sends a word with a single 1 through every bit position of the data bus in turn, from the least significant bit up to the most significant bit. Every word goes to one address, which is captured when the run starts. Each word is written, read back at once and compared before the next word is sent. A data line that is stuck at 0, stuck at 1, or tied to another line therefore shows up as a mismatch.

The run takes as many patterns as the bus has bits, not every possible value. When a run ends, `done` is raised together with either `pass` or `fail`. On a failure the engine stops at the first mismatch and holds both the word it expected and the word it read back. These two words show which line is faulty. If the data bus splits across several memory devices, software starts one run per device, each time with an address inside that device.

Top module: `dline_walk_bist`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pass_o`, `fail_o`, `mem_we_o` and `mem_re_o` are all 0.
- R2: Every write issued during a run carries a word with exactly one bit set. The k-th write of a run (k counted from 0) sets bit k, so the first write sets bit 0 and the last sets bit DATA_W-1.
- R3: Every write and read of a run uses the address on `test_addr_i` in the cycle the run was accepted, whatever `test_addr_i` does later.
- R4: Each write is followed in the very next cycle by a read of the same address. The read data is compared in the cycle after the read, and the next write comes only after that comparison, so each pattern takes three cycles.
- R5: When all DATA_W readbacks match, the run ends with `done_o`=1, `pass_o`=1 and `fail_o`=0, after exactly DATA_W writes.
- R6: At the first readback that differs from the written word, the run stops with no further write. `done_o`=1, `fail_o`=1 and `pass_o`=0 are raised, `exp_word_o` holds the written one-hot word and `got_word_o` holds the word read back.
- R7: A start pulse that arrives while a run is in progress is ignored. The run keeps its address and its pattern count.
- R8: A start accepted while idle clears `done_o`, `pass_o` and `fail_o` and raises `busy_o` in the following cycle.
- R9: `done_o`, `pass_o`, `fail_o`, `exp_word_o` and `got_word_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| test_addr_i | input | ADDR_W | Address used for the whole run, sampled on start |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read request; data expected one cycle later |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Registered memory read data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run has finished |
| pass_o | output | 1 | Last run found every line good |
| fail_o | output | 1 | Last run found a mismatch |
| exp_word_o | output | DATA_W | Word written at the failing step |
| got_word_o | output | DATA_W | Word read back at the failing step |

## Verification
The bench builds the engine with DATA_W=16 and ADDR_W=5. Sixteen lanes leave room for faults deep in the sequence and far apart: a short between bits 2 and 11, and a stuck-low fault on the most significant lane, which fails only at the very last pattern. The 5-bit address lets two runs target separate regions, standing in for a bus split across two devices. A stuck-high bit 0 exercises the case where the first pattern passes and the failure appears one step later.

// File: rtl/dline_walk_pkg.sv
package dline_walk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_CHECK = 2'd3
    } walk_phase_e;

endpackage

// File: rtl/dline_walk_pattern.sv
module dline_walk_pattern #(
    parameter int DATA_W = 8,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] word_o
);

    // One comparator per lane: lane g is high only when the step index equals g.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign word_o[g] = (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/dline_walk_seq.sv
module dline_walk_seq
    import dline_walk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mismatch_i,
    output logic              launch_o,
    output logic              we_o,
    output logic              re_o,
    output logic              check_o,
    output logic              last_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  idx_o
);

    typedef struct packed {
        walk_phase_e       phase;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        launch_o = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    launch_o   = 1'b1;
                    st_d.phase = PH_WRITE;
                    st_d.idx   = '0;
                    st_d.addr  = addr_i;
                end
            end
            PH_WRITE: st_d.phase = PH_READ;
            PH_READ:  st_d.phase = PH_CHECK;
            PH_CHECK: begin
                if (mismatch_i || (st_q.idx == LAST_IDX)) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.phase = PH_WRITE;
                    st_d.idx   = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o    = (st_q.phase == PH_WRITE);
    assign re_o    = (st_q.phase == PH_READ);
    assign check_o = (st_q.phase == PH_CHECK);
    assign last_o  = (st_q.idx == LAST_IDX);
    assign busy_o  = (st_q.phase != PH_IDLE);
    assign addr_o  = st_q.addr;
    assign idx_o   = st_q.idx;

    // R4
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> re_o && (addr_o == $past(addr_o)));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o || re_o) && start_i |=> busy_o && $stable(idx_o) && $stable(addr_o));

endmodule

// File: rtl/dline_walk_result.sv
module dline_walk_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              check_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] got_i,
    output logic              mismatch_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [DATA_W-1:0] exp_o,
    output logic [DATA_W-1:0] got_o
);

    typedef struct packed {
        logic              done;
        logic              pass;
        logic              fail;
        logic [DATA_W-1:0] exp_w;
        logic [DATA_W-1:0] got_w;
    } res_state_t;

    res_state_t st_d, st_q;

    assign mismatch_o = check_i && (exp_i != got_i);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (mismatch_o) begin
            st_d.done  = 1'b1;
            st_d.fail  = 1'b1;
            st_d.exp_w = exp_i;
            st_d.got_w = got_i;
        end else if (check_i && last_i) begin
            st_d.done = 1'b1;
            st_d.pass = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign pass_o = st_q.pass;
    assign fail_o = st_q.fail;
    assign exp_o  = st_q.exp_w;
    assign got_o  = st_q.got_w;

    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o) && (done_o || (!pass_o && !fail_o)));

    // R9
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !clear_i |=> done_o && $stable(pass_o) && $stable(fail_o)
                               && $stable(exp_o) && $stable(got_o));

endmodule

// File: rtl/dline_walk_bist.sv
module dline_walk_bist #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] test_addr_i,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [DATA_W-1:0] exp_word_o,
    output logic [DATA_W-1:0] got_word_o
);

    logic             launch;
    logic             check;
    logic             last;
    logic             mismatch;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] pattern;

    dline_walk_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .addr_i    (test_addr_i),
        .mismatch_i(mismatch),
        .launch_o  (launch),
        .we_o      (mem_we_o),
        .re_o      (mem_re_o),
        .check_o   (check),
        .last_o    (last),
        .busy_o    (busy_o),
        .addr_o    (mem_addr_o),
        .idx_o     (idx)
    );

    dline_walk_pattern #(.DATA_W(DATA_W)) u_pat (
        .idx_i (idx),
        .word_o(pattern)
    );

    dline_walk_result #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (launch),
        .check_i   (check),
        .last_i    (last),
        .exp_i     (pattern),
        .got_i     (mem_rdata_i),
        .mismatch_o(mismatch),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .fail_o    (fail_o),
        .exp_o     (exp_word_o),
        .got_o     (got_word_o)
    );

    assign mem_wdata_o = pattern;

    // R2
    onehot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $onehot(mem_wdata_o));

    // R6
    halt_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !mem_we_o && !mem_re_o);

    // R8
    launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !done_o && !pass_o && !fail_o);

endmodule

// File: tb/dline_walk_bist_bench.sv
module dline_walk_bist_bench;

    localparam int DW = 16;
    localparam int AW = 5;

    typedef struct {
        logic          pass;
        logic [DW-1:0] exp_w;
        logic [DW-1:0] got_w;
        int            writes;
        logic [AW-1:0] addr;
    } outcome_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] taddr = '0;
    logic we, re, busy, done, pass, fail;
    logic [AW-1:0] maddr;
    logic [DW-1:0] wdata, rdata, expw, gotw;

    int checks = 0;
    int errors = 0;
    outcome_t sb_q[$];

    // fault injection in the memory model
    logic [DW-1:0] stuck_hi = '0;
    logic [DW-1:0] stuck_lo = '0;
    logic          short_en = 1'b0;
    int            short_a = 0;
    int            short_b = 0;

    logic [DW-1:0] mem [2**AW];
    logic [DW-1:0] rdata_q = '0;

    always #10 clk = ~clk;

    dline_walk_bist #(.DATA_W(DW), .ADDR_W(AW)) u_dline_walk_bist (
        .clk(clk), .rst_n(rst_n), .start_i(start), .test_addr_i(taddr),
        .mem_we_o(we), .mem_re_o(re), .mem_addr_o(maddr), .mem_wdata_o(wdata),
        .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .pass_o(pass),
        .fail_o(fail), .exp_word_o(expw), .got_word_o(gotw)
    );

    function automatic logic [DW-1:0] damage(logic [DW-1:0] w);
        logic [DW-1:0] v = w;
        logic t;
        if (short_en) begin
            t = v[short_a] | v[short_b];
            v[short_a] = t;
            v[short_b] = t;
        end
        return (v | stuck_hi) & ~stuck_lo;
    endfunction

    always @(posedge clk) begin
        if (we) mem[maddr] <= damage(wdata);
        if (re) rdata_q <= mem[maddr];
    end
    assign rdata = rdata_q;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor state
    int  wcount = 0;
    bit  busy_p = 0, done_p = 0, we_p = 0;
    logic [AW-1:0] addr_p = '0;
    logic [AW-1:0] run_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_p) wcount = 0;
            if (we) begin
                // R2: k-th write sets bit k only
                check(wdata == (DW'(1) << wcount), "R2", "write pattern", wdata, DW'(1) << wcount);
                // R3: address fixed for the run
                check(maddr == run_addr, "R3", "write address", maddr, run_addr);
                wcount++;
            end
            if (re) begin
                // R4: read directly follows write at same address
                check(we_p && (maddr == addr_p), "R4", "read after write", {we_p, maddr}, {1'b1, addr_p});
            end
            if (we_p) check(re, "R4", "read slot after write", re, 1);
            if (done && !done_p) begin
                outcome_t e;
                if (sb_q.size() == 0) begin
                    check(0, "R5", "unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    if (e.pass) begin
                        check(pass && !fail, "R5", "pass verdict", {pass, fail}, 2'b10);
                    end else begin
                        check(fail && !pass, "R6", "fail verdict", {pass, fail}, 2'b01);
                        check(expw == e.exp_w, "R6", "expected word", expw, e.exp_w);
                        check(gotw == e.got_w, "R6", "read word", gotw, e.got_w);
                    end
                    check(wcount == e.writes, e.pass ? "R5" : "R6", "write count", wcount, e.writes);
                end
            end
            busy_p = busy; done_p = done; we_p = we; addr_p = maddr;
        end
    end

    task automatic run(input logic [AW-1:0] a, input bit poke_busy);
        outcome_t e;
        int cyc;
        e.pass = 1; e.exp_w = '0; e.got_w = '0; e.writes = DW; e.addr = a;
        for (int k = 0; k < DW; k++) begin
            logic [DW-1:0] p = DW'(1) << k;
            if (damage(p) != p) begin
                e.pass = 0; e.exp_w = p; e.got_w = damage(p); e.writes = k + 1;
                break;
            end
        end
        sb_q.push_back(e);
        @(negedge clk);
        taddr = a; start = 1'b1; run_addr = a;
        @(negedge clk);
        start = 1'b0;
        // R8: run launched, old verdict cleared
        check(busy && !done && !pass && !fail, "R8", "launch clears verdict",
              {busy, done, pass, fail}, 4'b1000);
        if (poke_busy) begin
            repeat (4) @(negedge clk);
            // R7: second start with another address while busy
            taddr = a ^ 5'h1F; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        repeat (5) @(negedge clk);
        // R9: verdict held while idle
        check(done && (pass == e.pass) && (fail == !e.pass) && !busy, "R9", "verdict held",
              {done, pass, fail, busy}, {1'b1, e.pass, !e.pass, 1'b0});
        if (!e.pass)
            check(expw == e.exp_w && gotw == e.got_w, "R9", "words held", expw, e.exp_w);
        stuck_hi = '0; stuck_lo = '0; short_en = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pass && !fail && !we && !re, "R1", "reset outputs",
              {busy, done, pass, fail, we, re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !we && !re, "R1", "idle after reset", {busy, done, we, re}, 0);

        run(5'd3, 0);                                  // R5 clean
        run(5'd17, 1);                                 // R5 second region, R7 start while busy
        stuck_lo = DW'(1) << 5; run(5'd8, 0);          // R6 stuck low mid
        stuck_hi = DW'(1) << 9; run(5'd8, 0);          // R6 stuck high, fails at first pattern
        stuck_hi = DW'(1); run(5'd2, 0);               // R6 bit 0 stuck high fails at step 1
        short_en = 1; short_a = 2; short_b = 11; run(5'd30, 0); // R6 tied lanes
        stuck_lo = DW'(1) << (DW - 1); run(5'd12, 1);  // R6 MSB fails last
        run(5'd0, 0);                                  // R8 pass after fail

        check(sb_q.size() == 0, "R5", "all runs finished", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule